// File: doc/BRIEF.md
# Strobed Bidirectional Bus Port Controller

This block runs one eight-bit peripheral bus in both directions with a full handshake. It serves only the first port group, and it keeps its own latch for each direction. On the CPU side, a write loads the outbound latch. When the write ends, the block flags "output buffer full" to the peripheral. The peripheral fetches the byte by pulling its acknowledge low. The bus driver is on only while acknowledge is held low, and the pins float at all other times. In the other direction, the peripheral pulls its strobe low to load the bus into the inbound latch, which sets "input buffer full". The CPU read that empties the latch clears that flag when the read ends.

Each direction has its own interrupt enable. Software sets or clears these through the single-bit set/reset command of the control port: bit 6 controls the output-side enable and bit 4 controls the input-side enable. A single interrupt line merges both service conditions. A five-bit status field feeds the upper part of the control-port read. Loading a new mode clears all handshake state. Every input is synchronous to `clk`. Each read or write strobe is a level that is high for as long as the access lasts.

Top module: `strobed_bidir_port`

## Requirements
- R1: After reset, `obf_n` is 1, `ibf` is 0, `intr` is 0, `pa_oe` is 0, and `status` is 5'b10000.
- R2: `pa_oe` is 1 exactly while `ack_n` is 0. While it is 1, `pa_out` carries the byte from the most recent CPU write. A written byte is never driven unless acknowledge is given.
- R3: `obf_n` goes to 0 on the clock edge that sees `cpu_wr` fall. A clock edge that sees `ack_n` low sets it back to 1. If both happen in the same cycle, the write end takes priority.
- R4: A clock edge that sees `stb_n` low loads `pa_in` into the inbound latch and sets `ibf`. The CPU reads the latch on `cpu_rdata`.
- R5: `ibf` stays 1 while `cpu_rd` is high. It clears on the clock edge that sees `cpu_rd` fall, unless a strobe arrives in that same cycle.
- R6: A set/reset command with `bsr_bit`=6 writes `bsr_val` into the output-side enable. With `bsr_bit`=4 it writes the input-side enable. Any other bit number leaves both enables unchanged.
- R7: `intr` = (`ibf` & input enable & `stb_n` & !`cpu_rd`) | (`obf_n` & output enable & `ack_n` & !`cpu_wr`). With both enables clear, `intr` stays 0.
- R8: Transfers in the two directions overlap without interference in any order, provided each write comes before its acknowledge and each strobe comes before its read.
- R9: A `mode_load` pulse clears both latches and both enables, and it leaves `obf_n`=1 and `ibf`=0.
- R10: `status` reads {`obf_n`, output enable, `ibf`, input enable, `intr`}, with the most significant bit first. These map to control-port read bits 7 down to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | One-cycle pulse when a mode word is written |
| cpu_wr | input | 1 | CPU write of the port, high for the whole access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read of the port, high for the whole access |
| cpu_rdata | output | 8 | Inbound latch contents |
| bsr_valid | input | 1 | Single-bit set/reset command valid |
| bsr_bit | input | 3 | Control-port bit number of the command |
| bsr_val | input | 1 | Value to write to that bit |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pa_in | input | 8 | Bus pins as seen from the peripheral |
| pa_out | output | 8 | Outbound latch value for the bus driver |
| pa_oe | output | 1 | Bus driver enable |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Merged interrupt request |
| status | output | 5 | Status field for control-port read bits 7..3 |

## Verification
On every cycle, assertions check the following rules:
- `obf_n` falls only after a write ends.
- An acknowledge empties the output buffer.
- A strobe fills the inbound latch with the sampled bus value.
- `ibf` drops only after a read ends or a mode load.
- Set/reset commands to foreign bits leave the enables untouched.
- The interrupt stays quiet when both enables are clear.
- A mode load clears the handshake state.

Only the bench scenarios can show the rest: end-to-end data movement through the scoreboard queues, the bus staying undriven across a write that gets no acknowledge, and interrupt masking in the middle of an access. They also cover both orders of overlapping inbound and outbound transfers and the exact value of the status field.

// File: rtl/strobed_bidir_pkg.sv
package strobed_bidir_pkg;
    localparam int DATA_W       = 8;
    localparam int BSR_W        = 3;
    localparam int INTE_OUT_BIT = 6;
    localparam int INTE_IN_BIT  = 4;

    typedef struct packed {
        logic obf_n;
        logic inte_out;
        logic ibf;
        logic inte_in;
        logic intr;
    } port_status_t;

    localparam int STATUS_W = $bits(port_status_t);

    function automatic logic merge_irq(input logic ibf, input logic inte_in,
                                       input logic stb_n, input logic rd,
                                       input logic obf_n, input logic inte_out,
                                       input logic ack_n, input logic wr);
        return (ibf & inte_in & stb_n & ~rd) | (obf_n & inte_out & ack_n & ~wr);
    endfunction
endpackage

// File: rtl/bidir_out_path.sv
module bidir_out_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          ack_n,
    output logic [DW-1:0] out_q,
    output logic          obf_n
);
    logic wr_q;
    logic wr_end;

    assign wr_end = wr_q & ~wr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            out_q <= '0;
            obf_n <= 1'b1;
            wr_q  <= 1'b0;
        end else begin
            wr_q <= wr;
            if (wr)
                out_q <= wdata;
            if (wr_end)
                obf_n <= 1'b0;
            else if (!ack_n)
                obf_n <= 1'b1;
        end
    end

    // R3
    obf_set_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(obf_n) |-> ($past(wr, 2) && !$past(wr)));

    // R3
    ack_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !wr_end) |=> obf_n);
endmodule

// File: rtl/bidir_in_path.sv
module bidir_in_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          stb_n,
    input  logic [DW-1:0] pa_in,
    input  logic          rd,
    output logic [DW-1:0] in_q,
    output logic          ibf
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            in_q <= '0;
            ibf  <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd;
            if (!stb_n) begin
                in_q <= pa_in;
                ibf  <= 1'b1;
            end else if (rd_q && !rd) begin
                ibf <= 1'b0;
            end
        end
    end

    // R4
    strobe_loads_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb_n && !clear) |=> (ibf && in_q == $past(pa_in)));

    // R5
    ibf_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ibf) |-> (($past(rd, 2) && !$past(rd)) || $past(clear)));
endmodule

// File: rtl/bidir_irq.sv
module bidir_irq
    import strobed_bidir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             bsr_valid,
    input  logic [BSR_W-1:0] bsr_bit,
    input  logic             bsr_val,
    input  logic             ibf,
    input  logic             obf_n,
    input  logic             stb_n,
    input  logic             ack_n,
    input  logic             rd,
    input  logic             wr,
    output logic             inte_out,
    output logic             inte_in,
    output logic             intr
);
    logic [1:0] inte_q;
    localparam logic [BSR_W-1:0] SEL_POS [2] = '{BSR_W'(INTE_OUT_BIT), BSR_W'(INTE_IN_BIT)};

    for (genvar g = 0; g < 2; g++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst || clear)
                inte_q[g] <= 1'b0;
            else if (bsr_valid && bsr_bit == SEL_POS[g])
                inte_q[g] <= bsr_val;
        end
    end

    assign inte_out = inte_q[0];
    assign inte_in  = inte_q[1];
    assign intr     = merge_irq(ibf, inte_in, stb_n, rd, obf_n, inte_out, ack_n, wr);

    // R6
    foreign_bit_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bsr_valid && bsr_bit != BSR_W'(INTE_OUT_BIT) && bsr_bit != BSR_W'(INTE_IN_BIT) && !clear)
        |=> ($stable(inte_out) && $stable(inte_in)));

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!inte_out && !inte_in) |-> !intr);
endmodule

// File: rtl/strobed_bidir_port.sv
module strobed_bidir_port
    import strobed_bidir_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_load,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic                cpu_rd,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic                bsr_valid,
    input  logic [BSR_W-1:0]    bsr_bit,
    input  logic                bsr_val,
    input  logic                stb_n,
    input  logic                ack_n,
    input  logic [DATA_W-1:0]   pa_in,
    output logic [DATA_W-1:0]   pa_out,
    output logic                pa_oe,
    output logic                obf_n,
    output logic                ibf,
    output logic                intr,
    output logic [STATUS_W-1:0] status
);
    logic         inte_out;
    logic         inte_in;
    port_status_t stat;

    bidir_out_path #(.DW(DATA_W)) u_out (
        .clk(clk), .rst(rst), .clear(mode_load), .wr(cpu_wr), .wdata(cpu_wdata),
        .ack_n(ack_n), .out_q(pa_out), .obf_n(obf_n)
    );

    bidir_in_path #(.DW(DATA_W)) u_in (
        .clk(clk), .rst(rst), .clear(mode_load), .stb_n(stb_n), .pa_in(pa_in),
        .rd(cpu_rd), .in_q(cpu_rdata), .ibf(ibf)
    );

    bidir_irq u_irq (
        .clk(clk), .rst(rst), .clear(mode_load), .bsr_valid(bsr_valid),
        .bsr_bit(bsr_bit), .bsr_val(bsr_val), .ibf(ibf), .obf_n(obf_n),
        .stb_n(stb_n), .ack_n(ack_n), .rd(cpu_rd), .wr(cpu_wr),
        .inte_out(inte_out), .inte_in(inte_in), .intr(intr)
    );

    assign pa_oe = ~ack_n;

    always_comb begin
        stat.obf_n    = obf_n;
        stat.inte_out = inte_out;
        stat.ibf      = ibf;
        stat.inte_in  = inte_in;
        stat.intr     = intr;
    end
    assign status = stat;

    // R9
    mode_clears_chk: assert property (@(posedge clk) disable iff (rst)
        mode_load |=> (obf_n && !ibf && !inte_out && !inte_in));
endmodule

// File: tb/strobed_bidir_port_test.sv
module strobed_bidir_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_load = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_rdata;
    logic       bsr_valid = 1'b0;
    logic [2:0] bsr_bit = '0;
    logic       bsr_val = 1'b0;
    logic       stb_n = 1'b1;
    logic       ack_n = 1'b1;
    logic [7:0] pa_in = '0;
    logic [7:0] pa_out;
    logic       pa_oe;
    logic       obf_n;
    logic       ibf;
    logic       intr;
    logic [4:0] status;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [7:0] exp_bus[$];
    logic [7:0] exp_rd[$];
    logic intr_mid;
    logic ibf_mid;

    strobed_bidir_port uut (
        .clk(clk), .rst(rst), .mode_load(mode_load), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .bsr_valid(bsr_valid), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
        .stb_n(stb_n), .ack_n(ack_n), .pa_in(pa_in), .pa_out(pa_out),
        .pa_oe(pa_oe), .obf_n(obf_n), .ibf(ibf), .intr(intr), .status(status)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic cpu_write(input logic [7:0] d, input bit push);
        if (push) exp_bus.push_back(d);
        cpu_wr = 1'b1;
        cpu_wdata = d;
        #1 intr_mid = intr;
        step();
        cpu_wr = 1'b0;
        step();
    endtask

    task automatic peri_ack();
        ack_n = 1'b0;
        step();
        ack_n = 1'b1;
        step();
    endtask

    task automatic peri_strobe(input logic [7:0] d, input bit push);
        if (push) exp_rd.push_back(d);
        pa_in = d;
        stb_n = 1'b0;
        step();
        stb_n = 1'b1;
        pa_in = 8'hxx;
        step();
    endtask

    task automatic cpu_read();
        cpu_rd = 1'b1;
        #1 intr_mid = intr;
        step();
        ibf_mid = ibf;
        cpu_rd = 1'b0;
        step();
    endtask

    task automatic bsr(input logic [2:0] b, input logic v);
        bsr_valid = 1'b1;
        bsr_bit = b;
        bsr_val = v;
        step();
        bsr_valid = 1'b0;
    endtask

    // Scoreboard monitor: pops expected bytes as the design presents them
    logic prev_oe = 1'b0;
    logic prev_rd = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pa_oe && !prev_oe) begin
                if (exp_bus.size() == 0) check("R2 unexpected drive", pa_out, 8'hxx);
                else check("R2 bus byte", pa_out, exp_bus.pop_front());
            end
            if (cpu_rd && !prev_rd) begin
                if (exp_rd.size() == 0) check("R4 unexpected read", cpu_rdata, 8'hxx);
                else check("R4 read byte", cpu_rdata, exp_rd.pop_front());
            end
        end
        prev_oe <= pa_oe;
        prev_rd <= cpu_rd;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 obf_n", obf_n, 1);
        check("R1 ibf", ibf, 0);
        check("R1 intr", intr, 0);
        check("R1 pa_oe", pa_oe, 0);
        check("R1 status", status, 5'b10000);

        // R3 write sets output full; R2 no drive without acknowledge
        cpu_write(8'hA5, 1);
        check("R3 obf after write", obf_n, 0);
        check("R2 undriven after write", pa_oe, 0);
        repeat (4) step();
        check("R2 still undriven", pa_oe, 0);
        check("R3 obf holds", obf_n, 0);
        peri_ack();
        check("R3 obf cleared by ack", obf_n, 1);
        check("R2 released after ack", pa_oe, 0);

        // R4 strobe, R5 read clears
        peri_strobe(8'h3C, 1);
        check("R4 ibf set", ibf, 1);
        cpu_read();
        check("R5 ibf held during read", ibf_mid, 1);
        check("R5 ibf cleared", ibf, 0);

        // R7 no enables -> quiet
        peri_strobe(8'h55, 1);
        check("R7 masked input", intr, 0);
        bsr(3'd4, 1'b1);
        check("R6 input enable", status[1], 1);
        check("R7 input request", intr, 1);
        cpu_read();
        check("R7 masked during read", intr_mid, 0);
        check("R7 quiet after read", intr, 0);

        bsr(3'd6, 1'b1);
        check("R6 output enable", status[3], 1);
        check("R7 output empty request", intr, 1);
        bsr(3'd2, 1'b0);
        check("R6 foreign bit out", status[3], 1);
        check("R6 foreign bit in", status[1], 1);
        bsr(3'd5, 1'b0);
        check("R6 foreign bit 5", status[1], 1);

        cpu_write(8'h96, 1);
        check("R7 masked during write", intr_mid, 0);
        check("R7 quiet while full", intr, 0);
        peri_ack();
        check("R7 request after ack", intr, 1);
        check("R10 status idle", status, 5'b11011);

        // R8 order A: write, strobe, ack, read
        cpu_write(8'h11, 1);
        peri_strobe(8'h22, 1);
        check("R10 status both full", status, 5'b01111);
        peri_ack();
        cpu_read();
        check("R8 order A obf", obf_n, 1);
        check("R8 order A ibf", ibf, 0);

        // R8 order B: strobe, write, read, ack
        peri_strobe(8'h33, 1);
        cpu_write(8'h44, 1);
        check("R8 order B both", {obf_n, ibf}, 2'b01);
        cpu_read();
        peri_ack();
        check("R8 order B obf", obf_n, 1);
        check("R8 order B ibf", ibf, 0);

        bsr(3'd6, 1'b0);
        check("R6 output enable cleared", status[3], 0);

        // R9 mode load clears pending state
        bsr(3'd6, 1'b1);
        cpu_write(8'h77, 0);
        peri_strobe(8'h88, 0);
        mode_load = 1'b1;
        step();
        mode_load = 1'b0;
        check("R9 obf_n", obf_n, 1);
        check("R9 ibf", ibf, 0);
        check("R9 status", status, 5'b10000);
        check("R9 intr", intr, 0);

        check("R2 bus queue drained", 8'(exp_bus.size()), 0);
        check("R4 read queue drained", 8'(exp_rd.size()), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule